// File: doc/BRIEF.md
# Multicycle Integer Vector Execution Unit

This block is a vector coprocessor datapath placed beside a small scalar core. It holds a bank of vector registers. Each register is made of VL lanes of 32-bit integers. The unit runs three operations: lane-wise addition, lane-wise multiplication, and a horizontal reduction that adds every lane of one register into a single 32-bit scalar. Each operation has its own fixed latency. While an operation is in flight the unit reports `busy`. Its completion is marked by a one-cycle `done` pulse in the same cycle as the write-back.

The core issues a command by raising `start` for one cycle. The command carries an opcode, a destination register index and two source register indices. The source operands are captured when the command is accepted. A full-width load port writes a whole register while the unit is idle. A full-width read port returns any register at any time, so software can set up operands and collect vector results.

Top module: `vec_exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every vector register, `scalar_out`, `busy` and `done` to zero.
- R2: When `load_en` is high and `busy` is low at a clock edge, `load_data` is written into register `load_sel`. `rd_data` always shows register `rd_sel` combinationally. Lane i occupies bits [32i+31:32i], so lane 0 is in the low bits.
- R3: A start with a valid opcode, received while `busy` is low, is accepted, and `busy` is high in the following cycle. A start received while `busy` is high is ignored and changes no register or output.
- R4: `done` is high for exactly one cycle per accepted command. It rises in the same cycle that `busy` falls, and that is the cycle in which the written result first becomes visible.
- R5: Opcode 2'b00 (vector add) writes the lane-wise sum of `src_a` and `src_b` into `dst_sel`, each lane wrapping modulo 2^32. `busy` stays high for exactly LAT_ADD cycles (default 1).
- R6: Opcode 2'b01 (vector multiply) writes the low 32 bits of each lane product of `src_a` and `src_b` into `dst_sel`. `busy` stays high for exactly LAT_MUL cycles (default 5).
- R7: Opcode 2'b10 (horizontal sum) places the sum modulo 2^32 of all lanes of `src_a` into `scalar_out`. No vector register is changed. `busy` stays high for exactly LAT_HSUM cycles (default 3).
- R8: `scalar_out` changes only at the completion of a horizontal sum.
- R9: A load request made while `busy` is high is ignored.
- R10: Opcode 2'b11 is reserved. A start carrying it is not accepted and raises neither `busy` nor `done`.
- R11: Operands are the register contents before the accepting clock edge. A load into a source register in that same cycle does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command issue strobe |
| opcode | input | 2 | 00 add, 01 multiply, 10 horizontal sum, 11 reserved |
| dst_sel | input | $clog2(NREG) | Destination vector register |
| src_a | input | $clog2(NREG) | First source register (the only source for horizontal sum) |
| src_b | input | $clog2(NREG) | Second source register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| scalar_out | output | 32 | Horizontal-sum result register |
| load_en | input | 1 | Full-width register load strobe |
| load_sel | input | $clog2(NREG) | Register to load |
| load_data | input | VL*32 | Value to load |
| rd_sel | input | $clog2(NREG) | Register to read |
| rd_data | output | VL*32 | Contents of register rd_sel |

## Verification
The bench builds the unit with VL = 3, which is not a power of two. This makes the adder-tree reduction pad an empty leaf, so a zero term must enter the sum without disturbing it. The latencies keep their defaults of 1, 5 and 3. This exercises the shortest latency, where `busy` lasts only one cycle, next to the longest, which leaves a wide window for stray starts and loads while the unit is busy. The bank keeps its eight registers, so every index from 0 to 7 is written and read back.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

   localparam int LANE_W = 32;

   typedef enum logic [1:0] {
      OP_VADD = 2'b00,
      OP_VMUL = 2'b01,
      OP_HSUM = 2'b10,
      OP_RSVD = 2'b11
   } vop_e;

endpackage

// File: rtl/vxu_regbank.sv
module vxu_regbank
   import vxu_pkg::*;
#(
   parameter int VL   = 4,
   parameter int NREG = 8,
   localparam int VW  = VL * LANE_W,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [IW-1:0] sel_a,
   input  logic [IW-1:0] sel_b,
   input  logic [IW-1:0] sel_x,
   output logic [VW-1:0] q_a,
   output logic [VW-1:0] q_b,
   output logic [VW-1:0] q_x,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_sel,
   input  logic [VW-1:0] wr_data
);

   logic [VW-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < NREG; r++) regs[r] <= '0;
      end else if (wr_en) begin
         regs[wr_sel] <= wr_data;
      end
   end

   assign q_a = regs[sel_a];
   assign q_b = regs[sel_b];
   assign q_x = regs[sel_x];

endmodule

// File: rtl/vxu_lane_alu.sv
module vxu_lane_alu
   import vxu_pkg::*;
#(
   parameter int VL  = 4,
   localparam int VW = VL * LANE_W
) (
   input  logic [VW-1:0] opnd_a,
   input  logic [VW-1:0] opnd_b,
   output logic [VW-1:0] lane_sum,
   output logic [VW-1:0] lane_prod
);

   for (genvar l = 0; l < VL; l++) begin : g_lane
      logic [LANE_W-1:0] a_l;
      logic [LANE_W-1:0] b_l;
      assign a_l = opnd_a[l*LANE_W +: LANE_W];
      assign b_l = opnd_b[l*LANE_W +: LANE_W];
      assign lane_sum[l*LANE_W +: LANE_W]  = a_l + b_l;
      assign lane_prod[l*LANE_W +: LANE_W] = a_l * b_l;
   end

endmodule

// File: rtl/vxu_hsum.sv
module vxu_hsum
   import vxu_pkg::*;
#(
   parameter int VL        = 4,
   parameter bit HSUM_TREE = 1'b1,
   localparam int VW       = VL * LANE_W
) (
   input  logic [VW-1:0]     vec_in,
   output logic [LANE_W-1:0] total
);

   if (HSUM_TREE) begin : g_tree
      localparam int P = 1 << $clog2(VL);
      logic [LANE_W-1:0] node [2*P-1];

      for (genvar i = 0; i < P; i++) begin : g_leaf
         if (i < VL) begin : g_used
            assign node[P-1+i] = vec_in[i*LANE_W +: LANE_W];
         end else begin : g_pad
            assign node[P-1+i] = '0;
         end
      end

      for (genvar n = 0; n < P-1; n++) begin : g_node
         assign node[n] = node[2*n+1] + node[2*n+2];
      end

      assign total = node[0];
   end else begin : g_chain
      always_comb begin
         total = '0;
         for (int l = 0; l < VL; l++) total = total + vec_in[l*LANE_W +: LANE_W];
      end
   end

endmodule

// File: rtl/vxu_ctrl.sv
module vxu_ctrl
   import vxu_pkg::*;
#(
   parameter int LAT_ADD  = 1,
   parameter int LAT_MUL  = 5,
   parameter int LAT_HSUM = 3,
   localparam int LAT_MAX = (LAT_ADD > LAT_MUL)
                            ? ((LAT_ADD > LAT_HSUM) ? LAT_ADD : LAT_HSUM)
                            : ((LAT_MUL > LAT_HSUM) ? LAT_MUL : LAT_HSUM),
   localparam int CW      = $clog2(LAT_MAX + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  vop_e op_in,
   output logic accept,
   output logic finish,
   output vop_e cur_op,
   output logic busy,
   output logic done
);

   logic [CW-1:0] remain;

   function automatic logic [CW-1:0] first_count(vop_e op);
      case (op)
         OP_VMUL: first_count = CW'(LAT_MUL - 1);
         OP_HSUM: first_count = CW'(LAT_HSUM - 1);
         default: first_count = CW'(LAT_ADD - 1);
      endcase
   endfunction

   assign accept = start && !busy && (op_in != OP_RSVD);
   assign finish = busy && (remain == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         remain <= '0;
         cur_op <= OP_VADD;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy   <= 1'b1;
            remain <= first_count(op_in);
            cur_op <= op_in;
         end else if (finish) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else if (busy) begin
            remain <= remain - 1'b1;
         end
      end
   end

endmodule

// File: rtl/vec_exec_unit.sv
module vec_exec_unit
   import vxu_pkg::*;
#(
   parameter int VL        = 4,
   parameter int NREG      = 8,
   parameter int LAT_ADD   = 1,
   parameter int LAT_MUL   = 5,
   parameter int LAT_HSUM  = 3,
   parameter bit HSUM_TREE = 1'b1,
   localparam int VW       = VL * LANE_W,
   localparam int IW       = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [1:0]    opcode,
   input  logic [IW-1:0] dst_sel,
   input  logic [IW-1:0] src_a,
   input  logic [IW-1:0] src_b,
   output logic          busy,
   output logic          done,
   output logic [31:0]   scalar_out,
   input  logic          load_en,
   input  logic [IW-1:0] load_sel,
   input  logic [VW-1:0] load_data,
   input  logic [IW-1:0] rd_sel,
   output logic [VW-1:0] rd_data
);

   if (VL < 1) begin : g_bad_vl
      $error("vec_exec_unit: VL must be at least 1");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("vec_exec_unit: NREG must be at least 2");
   end
   if (LAT_ADD < 1 || LAT_MUL < 1 || LAT_HSUM < 1) begin : g_bad_lat
      $error("vec_exec_unit: every latency must be at least 1");
   end

   logic          accept;
   logic          finish;
   vop_e          cur_op;
   logic [VW-1:0] bank_a;
   logic [VW-1:0] bank_b;
   logic [VW-1:0] opnd_a;
   logic [VW-1:0] opnd_b;
   logic [IW-1:0] dst_q;
   logic [VW-1:0] lane_sum;
   logic [VW-1:0] lane_prod;
   logic [31:0]   red_total;
   logic          wr_en;
   logic [IW-1:0] wr_sel;
   logic [VW-1:0] wr_data;
   logic          vec_wb;
   logic          load_ok;

   vxu_ctrl #(
      .LAT_ADD (LAT_ADD),
      .LAT_MUL (LAT_MUL),
      .LAT_HSUM(LAT_HSUM)
   ) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .op_in (vop_e'(opcode)),
      .accept(accept),
      .finish(finish),
      .cur_op(cur_op),
      .busy  (busy),
      .done  (done)
   );

   vxu_regbank #(
      .VL  (VL),
      .NREG(NREG)
   ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .sel_a  (src_a),
      .sel_b  (src_b),
      .sel_x  (rd_sel),
      .q_a    (bank_a),
      .q_b    (bank_b),
      .q_x    (rd_data),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data)
   );

   // operand capture at the accepting edge
   always_ff @(posedge clk) begin
      if (rst) begin
         opnd_a <= '0;
         opnd_b <= '0;
         dst_q  <= '0;
      end else if (accept) begin
         opnd_a <= bank_a;
         opnd_b <= bank_b;
         dst_q  <= dst_sel;
      end
   end

   vxu_lane_alu #(.VL(VL)) u_alu (
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .lane_sum (lane_sum),
      .lane_prod(lane_prod)
   );

   vxu_hsum #(.VL(VL), .HSUM_TREE(HSUM_TREE)) u_hsum (
      .vec_in(opnd_a),
      .total (red_total)
   );

   assign vec_wb  = finish && (cur_op != OP_HSUM);
   assign load_ok = load_en && !busy;
   assign wr_en   = vec_wb || load_ok;
   assign wr_sel  = vec_wb ? dst_q : load_sel;

   always_comb begin
      if (!vec_wb)                wr_data = load_data;
      else if (cur_op == OP_VMUL) wr_data = lane_prod;
      else                        wr_data = lane_sum;
   end

   always_ff @(posedge clk) begin
      if (rst)                              scalar_out <= '0;
      else if (finish && cur_op == OP_HSUM) scalar_out <= red_total;
   end

endmodule

// File: rtl/vxu_checker.sv
module vxu_checker #(
   parameter int LAT_ADD  = 1,
   parameter int LAT_MUL  = 5,
   parameter int LAT_HSUM = 3
) (
   input logic        clk,
   input logic        rst,
   input logic        start,
   input logic [1:0]  opcode,
   input logic        busy,
   input logic        done,
   input logic [31:0] scalar_out
);

   logic       taken;
   logic [1:0] seen_op;
   int         run_len;
   logic       rst_q;

   assign taken = start && !busy && (opcode != 2'b11);

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         seen_op <= 2'b00;
         run_len <= 0;
      end else if (taken) begin
         seen_op <= opcode;
         run_len <= 0;
      end else if (busy) begin
         run_len <= run_len + 1;
      end
   end

   // R1: outputs are cleared in the cycle after a reset edge
   always @(posedge clk) begin
      if (rst_q) begin
         a_r1_reset_clear: assert (!busy && !done && scalar_out == 32'd0)
            else $error("R1 reset did not clear outputs");
      end
   end

   a_r3_busy_after_start: assert property (@(posedge clk) disable iff (rst)
      taken |=> busy);

   a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r4_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);

   a_r5_add_latency: assert property (@(posedge clk) disable iff (rst)
      (done && seen_op == 2'b00) |-> (run_len == LAT_ADD));

   a_r6_mul_latency: assert property (@(posedge clk) disable iff (rst)
      (done && seen_op == 2'b01) |-> (run_len == LAT_MUL));

   a_r7_hsum_latency: assert property (@(posedge clk) disable iff (rst)
      (done && seen_op == 2'b10) |-> (run_len == LAT_HSUM));

   a_r8_scalar_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(scalar_out) |-> (done && seen_op == 2'b10));

   a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
      (start && !busy && opcode == 2'b11) |=> !busy);

endmodule

bind vec_exec_unit vxu_checker #(
   .LAT_ADD (LAT_ADD),
   .LAT_MUL (LAT_MUL),
   .LAT_HSUM(LAT_HSUM)
) u_vxu_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .opcode    (opcode),
   .busy      (busy),
   .done      (done),
   .scalar_out(scalar_out)
);

// File: tb/vec_exec_unit_test.sv
module vec_exec_unit_test;

   localparam int VL = 3;
   localparam int VW = VL * 32;
   localparam int LA = 1;
   localparam int LM = 5;
   localparam int LH = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [1:0]    opcode = 2'b00;
   logic [2:0]    dst_sel = '0;
   logic [2:0]    src_a = '0;
   logic [2:0]    src_b = '0;
   logic          busy;
   logic          done;
   logic [31:0]   scalar_out;
   logic          load_en = 1'b0;
   logic [2:0]    load_sel = '0;
   logic [VW-1:0] load_data = '0;
   logic [2:0]    rd_sel = '0;
   logic [VW-1:0] rd_data;

   always #2 clk = ~clk;

   vec_exec_unit #(.VL(VL)) uut (
      .clk(clk), .rst(rst), .start(start), .opcode(opcode),
      .dst_sel(dst_sel), .src_a(src_a), .src_b(src_b),
      .busy(busy), .done(done), .scalar_out(scalar_out),
      .load_en(load_en), .load_sel(load_sel), .load_data(load_data),
      .rd_sel(rd_sel), .rd_data(rd_data)
   );

   typedef struct {
      bit            is_scalar;
      logic [2:0]    dst;
      logic [VW-1:0] val;
      int            lat;
      string         req;
   } exp_t;

   exp_t          sb[$];
   logic [VW-1:0] mdl [8];
   logic [31:0]   mscalar;
   int            n_run  = 0;
   int            n_fail = 0;
   bit            finished = 0;

   task automatic chk(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] mk(logic [31:0] base, logic [31:0] step);
      logic [VW-1:0] v;
      for (int i = 0; i < VL; i++) v[i*32 +: 32] = base + 32'(i) * step;
      return v;
   endfunction

   function automatic logic [VW-1:0] vadd(logic [VW-1:0] a, logic [VW-1:0] b);
      logic [VW-1:0] v;
      for (int i = 0; i < VL; i++) v[i*32 +: 32] = a[i*32 +: 32] + b[i*32 +: 32];
      return v;
   endfunction

   function automatic logic [VW-1:0] vmul(logic [VW-1:0] a, logic [VW-1:0] b);
      logic [VW-1:0] v;
      logic [63:0]   p;
      for (int i = 0; i < VL; i++) begin
         p = {32'd0, a[i*32 +: 32]} * {32'd0, b[i*32 +: 32]};
         v[i*32 +: 32] = p[31:0];
      end
      return v;
   endfunction

   function automatic logic [31:0] hsum(logic [VW-1:0] a);
      logic [31:0] s = '0;
      for (int i = 0; i < VL; i++) s = s + a[i*32 +: 32];
      return s;
   endfunction

   // monitor: pops expected items as done pulses appear
   int run_cnt  = 0;
   bit prev_don = 0;
   always @(negedge clk) begin
      if (!rst) begin
         if (busy) run_cnt++;
         if (done) begin
            exp_t e;
            chk(!prev_don, "R4 done pulse wider than one cycle", VW'(prev_don), '0);
            chk(!busy, "R4 busy still high with done", VW'(busy), '0);
            if (sb.size() == 0) begin
               chk(1'b0, "R3 done without accepted command", VW'(1), '0);
            end else begin
               e = sb.pop_front();
               chk(run_cnt == e.lat, {e.req, " latency"}, VW'(run_cnt), VW'(e.lat));
               if (e.is_scalar)
                  chk(scalar_out == e.val[31:0], {e.req, " scalar"}, VW'(scalar_out), e.val);
               else
                  chk(rd_data == e.val, {e.req, " vector"}, rd_data, e.val);
            end
            run_cnt = 0;
         end
         prev_don = done;
      end
   end

   task automatic load(logic [2:0] sel, logic [VW-1:0] v);
      @(posedge clk); #1;
      load_en = 1'b1; load_sel = sel; load_data = v;
      @(posedge clk); #1;
      load_en = 1'b0;
      mdl[sel] = v;
   endtask

   task automatic rd_chk(logic [2:0] sel, string req);
      @(posedge clk); #1;
      rd_sel = sel;
      @(negedge clk);
      chk(rd_data == mdl[sel], req, rd_data, mdl[sel]);
   endtask

   // driver: compute expectation, push, issue
   task automatic push_and_start(logic [1:0] op, logic [2:0] d, logic [2:0] a, logic [2:0] b);
      exp_t e;
      e.dst = d;
      e.is_scalar = (op == 2'b10);
      case (op)
         2'b00: begin e.val = vadd(mdl[a], mdl[b]); e.lat = LA; e.req = "R5 add"; end
         2'b01: begin e.val = vmul(mdl[a], mdl[b]); e.lat = LM; e.req = "R6 mul"; end
         default: begin e.val = VW'(hsum(mdl[a])); e.lat = LH; e.req = "R7 hsum"; end
      endcase
      if (e.is_scalar) mscalar = e.val[31:0];
      else             mdl[d] = e.val;
      sb.push_back(e);
      @(posedge clk); #1;
      start = 1'b1; opcode = op; dst_sel = d; src_a = a; src_b = b;
      if (!e.is_scalar) rd_sel = d;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic issue(logic [1:0] op, logic [2:0] d, logic [2:0] a, logic [2:0] b);
      push_and_start(op, d, a, b);
      wait_idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 8; r++) mdl[r] = '0;
      mscalar = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(!busy && !done, "R1 busy/done after reset", VW'({busy, done}), '0);
      chk(scalar_out == 0, "R1 scalar after reset", VW'(scalar_out), '0);
      for (int r = 0; r < 8; r++) rd_chk(3'(r), "R1 register cleared");

      // R2: fill every register, lane 0 in low bits
      load(3'd0, mk(32'hFFFF_FFF0, 32'd8));
      load(3'd1, mk(32'h0000_0020, 32'd1));
      load(3'd2, mk(32'h1234_5678, 32'h1111_1111));
      load(3'd3, mk(32'h9ABC_DEF0, 32'd3));
      load(3'd4, mk(32'h0000_0007, 32'h0000_0100));
      load(3'd5, mk(32'h8000_0000, 32'h4000_0000));
      load(3'd6, mk(32'h0BAD_F00D, 32'd1));
      load(3'd7, mk(32'hCAFE_0000, 32'd2));
      for (int r = 0; r < 8; r++) rd_chk(3'(r), "R2 load readback");
      @(posedge clk); #1 rd_sel = 3'd4;
      @(negedge clk);
      chk(rd_data[31:0] == 32'h0000_0007, "R2 lane 0 position", VW'(rd_data[31:0]), VW'(32'h7));

      // R5: wrapping add, and a second pattern
      issue(2'b00, 3'd2, 3'd0, 3'd1);
      issue(2'b00, 3'd7, 3'd5, 3'd5);
      // R6: multiply keeps low 32 bits
      issue(2'b01, 3'd6, 3'd2, 3'd3);
      issue(2'b01, 3'd1, 3'd4, 3'd4);
      chk(scalar_out == mscalar, "R8 scalar unchanged by vector ops", VW'(scalar_out), VW'(mscalar));
      // R7: reduction into scalar, bank unchanged
      issue(2'b10, 3'd3, 3'd0, 3'd0);
      for (int r = 0; r < 8; r++) rd_chk(3'(r), "R7 bank unchanged by hsum");
      issue(2'b10, 3'd0, 3'd5, 3'd1);
      chk(scalar_out == mscalar, "R8 scalar holds after hsum", VW'(scalar_out), VW'(mscalar));

      // R3 and R9: stray start and load during a multiply
      push_and_start(2'b01, 3'd4, 3'd6, 3'd7);
      @(posedge clk); #1;
      start = 1'b1; opcode = 2'b00; dst_sel = 3'd5; src_a = 3'd0; src_b = 3'd1;
      load_en = 1'b1; load_sel = 3'd7; load_data = mk(32'hDEAD_BEEF, 32'd5);
      @(posedge clk); #1;
      start = 1'b0; load_en = 1'b0;
      wait_idle();
      rd_chk(3'd5, "R3 start while busy ignored");
      rd_chk(3'd7, "R9 load while busy ignored");
      rd_chk(3'd4, "R6 result after stray inputs");

      // R10: reserved opcode
      @(posedge clk); #1;
      start = 1'b1; opcode = 2'b11; dst_sel = 3'd0;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      chk(!busy, "R10 reserved opcode leaves busy low", VW'(busy), '0);
      repeat (3) @(negedge clk);
      rd_chk(3'd0, "R10 reserved opcode writes nothing");

      // R11: load into a source on the accepting edge
      begin
         exp_t e;
         e.is_scalar = 0; e.dst = 3'd5; e.lat = LA; e.req = "R11 old operand";
         e.val = vadd(mdl[3], mdl[4]);
         mdl[5] = e.val;
         sb.push_back(e);
         @(posedge clk); #1;
         start = 1'b1; opcode = 2'b00; dst_sel = 3'd5; src_a = 3'd3; src_b = 3'd4;
         rd_sel = 3'd5;
         load_en = 1'b1; load_sel = 3'd3; load_data = mk(32'h0102_0304, 32'd9);
         mdl[3] = mk(32'h0102_0304, 32'd9);
         @(posedge clk); #1;
         start = 1'b0; load_en = 1'b0;
         wait_idle();
         rd_chk(3'd3, "R11 same-cycle load taken");
      end

      chk(sb.size() == 0, "R4 every command completed", VW'(sb.size()), '0);
      repeat (4) @(posedge clk);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule